// File: doc/BRIEF.md
# Self-Timed Ripple Adder with Carry Completion Detection

This block is a clocked model of a self-timed ripple-carry adder. Its latency follows the operands rather than a fixed worst case. Each carry between bit positions is held as a two-rail code. A pair with both rails low has not been computed yet. A pair with only the false rail high says the carry is zero, and a pair with only the true rail high says the carry is one.

A start pulse captures the operands and the carry-in and empties every carry pair. From then on, each clock counts as one step:

- A position whose operand bits agree settles its carry in the first step, because it either generates or kills the carry.
- A position whose operand bits differ propagates: it copies the carry of the position below it one step after that carry has settled.

A completion detector watches all pairs. Once every pair has settled, it raises `done` and freezes the step count. The result is therefore ready after the longest carry chain actually present, plus one step, instead of after the full width. The step count is available at a port, so the surrounding logic or a test can read how long the addition took.

Top module: `dr_carry_adder`

## Requirements
- R1: After reset, `done` is 0, `sum` is 0, `cout` is 0 and `steps` is 0.
- R2: While `done` is 1, the value {`cout`,`sum`} equals `a` + `b` + `cin` as captured at the last start.
- R3: Each carry pair uses the encoding 2'b00 = unresolved, 2'b01 = carry false and 2'b10 = carry true. The code 2'b11 never appears.
- R4: Between two starts, a carry pair changes at most once, and only from 2'b00 to a valid code.
- R5: A position where both operand bits are equal settles in the first step after start: 2'b10 when both are 1, and 2'b01 when both are 0.
- R6: A propagating position settles one step after the position below it. Bit 0 uses the carry-in, which counts as already settled. `steps` therefore equals the maximum over positions of t(i), where t(i)=1 if a[i]==b[i], t(0)=1, and otherwise t(i)=t(i-1)+1.
- R7: Adding 1 to the all-ones value takes W steps, which is the worst case, and gives `cout`=1 and `sum`=0.
- R8: Adding 1 to 0, or any case without a ripple, completes in 1 step.
- R9: Once `done` is 1, `done`, `sum`, `cout` and `steps` hold their values until the next start.
- R10: A start that arrives while an addition is in flight abandons that addition. The new operands are used, and `done` stays 0 until the new result settles.
- R11: The carry-in enters at bit 0 as a settled pair. With `a` all ones, `b`=0 and `cin`=1, the result has `cout`=1, `sum`=0 and `steps`=W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Step clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that captures the operands and begins an addition |
| a | input | W | First operand |
| b | input | W | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Result bits, valid while done is 1, otherwise 0 |
| cout | output | 1 | Carry out of the top bit, valid while done is 1 |
| done | output | 1 | All carry pairs have settled |
| steps | output | $clog2(W+1) | Steps taken from start to done |

## Verification
The operand patterns are chosen to separate the ways a carry can settle:

- **Equal operands** make every position generate or kill, so they isolate first-step settling.
- **Zero plus one** shows that a missing ripple still costs exactly one step.
- **All ones plus one** drives a chain through every position from a generated carry, while **all ones plus zero with carry-in set** drives the same chain from the carry-in side. Together they tell the carry-in entry apart from an ordinary generate.
- **Random operands** mix runs of many lengths and check the latency formula against a model computed position by position.
- A **restart during a long chain** shows that the stale operands leave no trace.

// File: rtl/dr_add_pkg.sv
package dr_add_pkg;
  typedef logic [1:0] dr_t;

  localparam dr_t DR_EMPTY = 2'b00;
  localparam dr_t DR_FALSE = 2'b01;
  localparam dr_t DR_TRUE  = 2'b10;

  function automatic logic dr_valid(input dr_t p);
    return p == DR_FALSE || p == DR_TRUE;
  endfunction

  function automatic dr_t dr_from_bit(input logic v);
    return v ? DR_TRUE : DR_FALSE;
  endfunction

  function automatic logic dr_is_true(input dr_t p);
    return p == DR_TRUE;
  endfunction

  // Sum bit of one position, given its carry-in pair.
  function automatic logic dr_sum_bit(input logic x, input logic y, input dr_t c);
    return x ^ y ^ dr_is_true(c);
  endfunction
endpackage

// File: rtl/dr_carry_cell.sv
module dr_carry_cell
  import dr_add_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step_en,
  input  logic a_bit,
  input  logic b_bit,
  input  dr_t  c_in,
  output dr_t  c_out
);
  logic gen_or_kill;
  logic take_lower;

  assign gen_or_kill = (a_bit == b_bit);
  assign take_lower  = !gen_or_kill && dr_valid(c_in);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              c_out <= DR_EMPTY;
    else if (clr)                            c_out <= DR_EMPTY;
    else if (step_en && c_out == DR_EMPTY) begin
      if (gen_or_kill)                       c_out <= dr_from_bit(a_bit);
      else if (take_lower)                   c_out <= c_in;
    end
  end

  AST_NO_BOTH_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    c_out != 2'b11); // R3
  AST_SETTLE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && c_out != DR_EMPTY) |=> c_out == $past(c_out)); // R4
  AST_FIRST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && step_en && c_out == DR_EMPTY && gen_or_kill) |=> c_out == dr_from_bit($past(a_bit))); // R5
endmodule

// File: rtl/dr_done_detect.sv
module dr_done_detect
  import dr_add_pkg::*;
#(
  parameter int W = 32
) (
  input  dr_t  pairs [W],
  output logic all_settled
);
  logic [W-1:0] settled;

  for (genvar i = 0; i < W; i++) begin : g_chk
    assign settled[i] = dr_valid(pairs[i]);
  end

  assign all_settled = &settled;
endmodule

// File: rtl/dr_step_counter.sv
module dr_step_counter #(
  parameter int SW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [SW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (inc) count <= count + 1'b1;
  end
endmodule

// File: rtl/dr_carry_adder.sv
module dr_carry_adder
  import dr_add_pkg::*;
#(
  parameter int W  = 32,
  localparam int SW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic          cin,
  output logic [W-1:0]  sum,
  output logic          cout,
  output logic          done,
  output logic [SW-1:0] steps
);
  logic [W-1:0] a_q, b_q;
  logic         cin_q;
  logic         active;
  logic         all_settled;
  logic         step_en;
  dr_t          co [W];
  dr_t          ci [W];
  logic [W-1:0] sum_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0; b_q <= '0; cin_q <= 1'b0; active <= 1'b0;
    end else if (start) begin
      a_q <= a; b_q <= b; cin_q <= cin; active <= 1'b1;
    end
  end

  assign step_en = active && !all_settled;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign ci[i] = dr_from_bit(cin_q);
    end else begin : g_up
      assign ci[i] = co[i-1];
    end
    dr_carry_cell u_cell (
      .clk(clk), .rst_n(rst_n), .clr(start), .step_en(step_en),
      .a_bit(a_q[i]), .b_bit(b_q[i]), .c_in(ci[i]), .c_out(co[i])
    );
    assign sum_raw[i] = dr_sum_bit(a_q[i], b_q[i], ci[i]);
  end

  dr_done_detect #(.W(W)) u_done (.pairs(co), .all_settled(all_settled));

  dr_step_counter #(.SW(SW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(start), .inc(step_en), .count(steps)
  );

  assign done = active && all_settled;
  assign sum  = done ? sum_raw : '0;
  assign cout = done && dr_is_true(co[W-1]);

  AST_RESULT_OK: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> {cout, sum} == ({1'b0, a_q} + {1'b0, b_q} + {{W{1'b0}}, cin_q})); // R2
  AST_STEPS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (steps >= SW'(1) && steps <= SW'(W))); // R6
  AST_HOLD_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(sum) && $stable(steps) && $stable(cout))); // R9
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done); // R10
endmodule

// File: tb/dr_carry_adder_test.sv
module dr_carry_adder_test;
  localparam int TW = 16;
  localparam int SW = $clog2(TW + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [TW-1:0] a_i = '0, b_i = '0;
  logic cin_i = 1'b0;
  logic [TW-1:0] sum;
  logic cout, done;
  logic [SW-1:0] steps;

  int checks = 0;
  int errors = 0;
  bit armed = 1'b0;
  int wait_cnt = 0;

  typedef struct { logic [TW:0] res; int stp; string req; } exp_t;
  exp_t q[$];

  always #4 clk = ~clk;

  dr_carry_adder #(.W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a_i), .b(b_i), .cin(cin_i),
    .sum(sum), .cout(cout), .done(done), .steps(steps)
  );

  // Latency model: settle time per position, worked out position by position.
  function automatic int model_steps(logic [TW-1:0] x, logic [TW-1:0] y);
    int t = 0, mx = 0;
    for (int i = 0; i < TW; i++) begin
      if (x[i] == y[i] || i == 0) t = 1;
      else t = t + 1;
      if (t > mx) mx = t;
    end
    return mx;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard when a result settles.
  always @(negedge clk) begin
    exp_t e;
    if (armed) begin
      if (done) begin
        e = q.pop_front();
        check({e.req, " result"}, 64'({cout, sum}), 64'(e.res));
        check({e.req, " steps"}, 64'(steps), 64'(e.stp));
        armed = 1'b0;
        wait_cnt = 0;
      end else begin
        wait_cnt++;
        if (wait_cnt > 4 * TW + 4) begin
          e = q.pop_front();
          check({e.req, " timeout"}, 64'(0), 64'(1));
          armed = 1'b0;
          wait_cnt = 0;
        end
      end
    end
  end

  task automatic run(logic [TW-1:0] x, logic [TW-1:0] y, logic c, string req);
    exp_t e;
    e.res = {1'b0, x} + {1'b0, y} + {{TW{1'b0}}, c};
    e.stp = model_steps(x, y);
    e.req = req;
    q.push_back(e);
    @(negedge clk);
    a_i = x; b_i = y; cin_i = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    armed = 1'b1;
    wait (armed == 1'b0);
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [TW-1:0] s_hold;
    logic [SW-1:0] st_hold;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 done", 64'(done), 64'(0));
    check("R1 sum", 64'({cout, sum}), 64'(0));
    check("R1 steps", 64'(steps), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);

    run('0, TW'(1), 1'b0, "R8 zero plus one");
    run(TW'(16'h5a3c), TW'(16'h5a3c), 1'b0, "R5 equal operands");
    run(TW'(16'h0f0f), TW'(16'h0f0f), 1'b1, "R5 equal operands cin");
    run('1, TW'(1), 1'b0, "R7 all ones plus one");
    run('1, '0, 1'b1, "R11 carry-in ripple");
    run('1, '0, 1'b0, "R6 propagate no carry");
    run(TW'(16'h00f0), TW'(16'h0f10), 1'b0, "R6 mid run");

    // R9: hold after done
    s_hold = sum; st_hold = steps;
    repeat (5) @(negedge clk);
    check("R9 done held", 64'(done), 64'(1));
    check("R9 sum held", 64'(sum), 64'(s_hold));
    check("R9 steps held", 64'(steps), 64'(st_hold));

    // R10: restart during a long chain
    @(negedge clk);
    a_i = '1; b_i = TW'(1); cin_i = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    check("R10 busy done low", 64'(done), 64'(0));
    run(TW'(16'h1234), TW'(16'h4321), 1'b1, "R10 restart result");

    // R2 R3 R4 R6: random operands against the model
    for (int k = 0; k < 40; k++) begin
      run(TW'($urandom), TW'($urandom), 1'($urandom), "R2 R6 random");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule